// File: doc/BRIEF.md
# DS1 Bit-Stuffing Synchronizer Store

This block takes one DS1 or E1 tributary, one bit per tributary clock on which the write enable is high, and holds it in a 16-entry, one-bit-wide elastic store. A DS2 frame generator on a separate clock drains that store. The framer raises `rd_en` on each slot that must carry tributary data. On each stuff opportunity it raises `stuff_opp` and receives `stuff_req` in the same cycle. When the store is running short, `stuff_req` tells the framer to insert a stuff bit. Otherwise the opportunity carries a data bit drawn from the store. Because the framer runs at a fixed rate and the stuff decision follows the fill level, the tributary can drift by ±130 ppm and carry several unit intervals of jitter without slipping.

The write pointer crosses into the read domain as Gray code through a synchronizer chain. The fill level, the stuff decision and both slip flags live on the read side. A slip sets the overflow or underflow flag, which stays set until the framer pulses `recenter`. The recenter pulse also pulls the read pointer back to half depth behind the write pointer. Mode code `10` bypasses the store entirely: the tributary bit appears at the output without buffering, and the store is left untouched.

Top module: `ds1_stuff_sync`

## Requirements
- R1: After reset the fill level reads 8, both slip flags read 0, and `rd_bit` reads 0.
- R2: In the buffered modes (`mode` 00, 01, 11), bits leave in the order they were written, one per read. `rd_bit` shows the bit one read clock after the read slot.
- R3: Each write raises the read-domain fill by one from the second read clock after the write. Each read lowers the fill from the read clock edge that performs it. At rest the fill equals 8 plus writes minus reads.
- R4: `stuff_req` is high exactly when `stuff_opp` is high, the store is not bypassed, and the fill is below 8. It is combinational in the same cycle.
- R5: A stuff opportunity with `stuff_req` high reads nothing. One with `stuff_req` low reads one data bit, just as `rd_en` does.
- R6: A read requested at fill 0 leaves the read pointer and the fill unchanged and sets the sticky `underflow` flag.
- R7: A fill above 16 sets the sticky `overflow` flag one read clock after the fill shows it. A fill of exactly 16 does not set it.
- R8: A `recenter` pulse clears both flags and sets the fill to 8. The following reads return the 8 most recently written bits, oldest first.
- R9: With `mode` = 10, `rd_bit` equals `wr_bit` combinationally and `stuff_req` stays low. Writes and reads leave the fill and the stored bits unchanged.
- R10: The Gray-coded write pointer changes in at most one bit per tributary clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Tributary line clock |
| rd_clk | input | 1 | DS2 frame-generation clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode | input | 2 | Operating mode; 10 bypasses the store |
| wr_en | input | 1 | Tributary bit valid on this line clock |
| wr_bit | input | 1 | Tributary data bit |
| rd_en | input | 1 | Framer data slot: read one bit |
| stuff_opp | input | 1 | Framer stuff opportunity in this cycle |
| recenter | input | 1 | Re-centre the pointers and clear the slip flags |
| rd_bit | output | 1 | Bit delivered to the framer |
| stuff_req | output | 1 | Use the current opportunity as a stuff bit |
| fill | output | 6 | Read-domain fill level |
| overflow | output | 1 | Sticky overflow slip flag |
| underflow | output | 1 | Sticky underflow slip flag |

## Verification
Both clocks are driven from one source so the timing can be predicted. `stuff_req` and the bypass output are combinational, so they are sampled 1 ns after the inputs change and before any edge. A read shows up on `rd_bit` and `fill` after the same edge. A write reaches `fill` only two edges later, and `overflow` one edge after that. For this reason, every fill or overflow check follows a four-cycle idle gap. Data checks compare each read against a queue of written bits kept in the bench. A recenter reloads that queue with the last eight bits written.

// File: rtl/ds1_sync_pkg.sv
package ds1_sync_pkg;
   localparam logic [1:0] MODE_DS1    = 2'b00;
   localparam logic [1:0] MODE_ALT    = 2'b01;
   localparam logic [1:0] MODE_BYPASS = 2'b10;
   localparam logic [1:0] MODE_SPARE  = 2'b11;
endpackage

// File: rtl/ds1_sync_cdc.sv
module ds1_sync_cdc #(
   parameter int          W        = 6,
   parameter int          STAGES   = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ds1_sync_cdc: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else if (s == 0) chain_q[s] <= d;
            else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ds1_sync_wr.sv
module ds1_sync_wr #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 2
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_bit,
   output logic [DEPTH-1:0] store,
   output logic [PW-1:0]    wr_gray
);
   localparam logic [PW-1:0] START = PW'(DEPTH / 2);

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] nxt_ptr;

   assign nxt_ptr = wr_ptr + PW'(1);

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= START;
         wr_gray <= START ^ (START >> 1);
         store   <= '0;
      end else if (wr_en) begin
         store[wr_ptr[AW-1:0]] <= wr_bit;
         wr_ptr  <= nxt_ptr;
         wr_gray <= nxt_ptr ^ (nxt_ptr >> 1);
      end
   end

   // R10
   gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      1'b1 |=> $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/ds1_sync_rd.sv
module ds1_sync_rd #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 2
) (
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             bypass,
   input  logic [PW-1:0]    wsync_gray,
   input  logic [DEPTH-1:0] store,
   input  logic             rd_en,
   input  logic             stuff_opp,
   input  logic             recenter,
   output logic             data_q,
   output logic             stuff_req,
   output logic [PW-1:0]    fill,
   output logic             overflow,
   output logic             underflow
);
   localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
   localparam logic [PW-1:0] FULL = PW'(DEPTH);

   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] wsync_bin;
   logic          rd_fire;
   logic          empty;

   always_comb begin
      for (int i = 0; i < PW; i++) wsync_bin[i] = ^(wsync_gray >> i);
   end

   assign fill      = wsync_bin - rd_ptr;
   assign empty     = (fill == '0);
   assign stuff_req = !bypass && stuff_opp && (fill < HALF);
   assign rd_fire   = !bypass && (rd_en || (stuff_opp && !stuff_req));

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr    <= '0;
         data_q    <= 1'b0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else if (recenter) begin
         rd_ptr    <= wsync_bin - HALF;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         if (rd_fire && !empty) begin
            rd_ptr <= rd_ptr + PW'(1);
            data_q <= store[rd_ptr[AW-1:0]];
         end
         if (rd_fire && empty) underflow <= 1'b1;
         if (fill > FULL) overflow <= 1'b1;
      end
   end

   // R6
   udf_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_fire && empty && !recenter) |=> (rd_ptr == $past(rd_ptr)) && underflow);
   // R6
   udf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (underflow && !recenter) |=> underflow);
   // R7
   ovf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (overflow && !recenter) |=> overflow);
   // R5
   stuff_no_read_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (stuff_req && !rd_en && !recenter) |=> rd_ptr == $past(rd_ptr));
   // R8
   recenter_clear_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      recenter |=> !overflow && !underflow);
endmodule

// File: rtl/ds1_stuff_sync.sv
module ds1_stuff_sync
   import ds1_sync_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit BYPASS_EN   = 1'b1,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 2
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          wr_en,
   input  logic          wr_bit,
   input  logic          rd_en,
   input  logic          stuff_opp,
   input  logic          recenter,
   output logic          rd_bit,
   output logic          stuff_req,
   output logic [PW-1:0] fill,
   output logic          overflow,
   output logic          underflow
);
   localparam logic [PW-1:0] START = PW'(DEPTH / 2);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ds1_stuff_sync: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   logic             bypass;
   logic [DEPTH-1:0] store;
   logic [PW-1:0]    wr_gray;
   logic [PW-1:0]    wsync_gray;
   logic             data_q;

   generate
      if (BYPASS_EN) begin : g_bypass
         assign bypass = (mode == MODE_BYPASS);
      end else begin : g_no_bypass
         logic unused_mode;
         assign unused_mode = ^mode;
         assign bypass      = 1'b0;
      end
   endgenerate

   ds1_sync_wr #(.DEPTH(DEPTH)) i_wr (
      .wr_clk  (wr_clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && !bypass),
      .wr_bit  (wr_bit),
      .store   (store),
      .wr_gray (wr_gray)
   );

   ds1_sync_cdc #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(START ^ (START >> 1))) i_cdc (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wr_gray),
      .q     (wsync_gray)
   );

   ds1_sync_rd #(.DEPTH(DEPTH)) i_rd (
      .rd_clk     (rd_clk),
      .rst_n      (rst_n),
      .bypass     (bypass),
      .wsync_gray (wsync_gray),
      .store      (store),
      .rd_en      (rd_en),
      .stuff_opp  (stuff_opp),
      .recenter   (recenter),
      .data_q     (data_q),
      .stuff_req  (stuff_req),
      .fill       (fill),
      .overflow   (overflow),
      .underflow  (underflow)
   );

   assign rd_bit = bypass ? wr_bit : data_q;

   // R9
   bypass_fill_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (bypass && $past(bypass) && !recenter && $stable(wsync_gray)) |=> $stable(fill));
endmodule

// File: tb/test_ds1_stuff_sync.sv
module test_ds1_stuff_sync;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, stuff_opp = 1'b0, recenter = 1'b0;
   logic       rd_bit, stuff_req, overflow, underflow;
   logic [5:0] fill;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit q[$];
   bit hist[$];

   always #5 clk = ~clk;

   ds1_stuff_sync i_ds1_stuff_sync (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .mode(mode),
      .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en), .stuff_opp(stuff_opp),
      .recenter(recenter), .rd_bit(rd_bit), .stuff_req(stuff_req),
      .fill(fill), .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic wb, input logic re,
                       input logic so, input logic rc);
      wr_en = we; wr_bit = wb; rd_en = re; stuff_opp = so; recenter = rc;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; rd_en = 0; stuff_opp = 0; recenter = 0;
   endtask

   task automatic idle();
      repeat (4) step(0, 0, 0, 0, 0);
   endtask

   task automatic do_write(input bit b);
      step(1, b, 0, 0, 0);
      q.push_back(b);
      hist.push_back(b);
   endtask

   task automatic do_read(input string req);
      bit e;
      step(0, 0, 1, 0, 0);
      e = q.pop_front();
      chk(req, rd_bit, e);
   endtask

   task automatic do_recenter();
      step(0, 0, 0, 0, 1);
      q.delete();
      for (int i = hist.size() - 8; i < hist.size(); i++) q.push_back(hist[i]);
   endtask

   task automatic probe_stuff(input int lvl, input string req);
      stuff_opp = 1'b1;
      #1;
      chk(req, stuff_req, (lvl < 8) ? 1 : 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin q.push_back(1'b0); hist.push_back(1'b0); end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 fill", fill, 8);
      chk("R1 overflow", overflow, 0);
      chk("R1 underflow", underflow, 0);
      chk("R1 rd_bit", rd_bit, 0);

      // R2 R3: balanced traffic in each buffered mode
      for (int m = 0; m < 4; m++) begin
         if (m == 2) continue;
         mode = 2'(m);
         for (int n = 0; n < 40; n++) begin
            bit b, e;
            b = 1'((n * 7 + m * 3) % 5 < 2);
            step(1, b, 1, 0, 0);
            e = q.pop_front();
            q.push_back(b); hist.push_back(b);
            chk("R2 data order", rd_bit, e);
         end
         idle();
         chk("R3 fill at rest", fill, q.size());
         chk("R7 no overflow", overflow, 0);
      end
      mode = 2'b00;

      // R4 R5: drain from 8 to 0 through stuff opportunities
      for (int lvl = 8; lvl >= 1; lvl--) begin
         chk("R3 fill level", fill, lvl);
         probe_stuff(lvl, "R4 stuff on drain");
         step(0, 0, 0, 1, 0);
         if (lvl >= 8) begin
            bit e;
            e = q.pop_front();
            chk("R5 opportunity carries data", rd_bit, e);
            chk("R5 fill after data read", fill, lvl - 1);
         end else begin
            chk("R5 stuff reads nothing", fill, lvl);
            do_read("R2 drain read");
         end
      end
      probe_stuff(0, "R4 stuff at empty");
      stuff_opp = 1'b0;

      // R6 underflow
      step(0, 0, 1, 0, 0);
      chk("R6 underflow set", underflow, 1);
      chk("R6 fill held", fill, 0);
      idle();
      chk("R6 underflow sticky", underflow, 1);

      // R8 recenter from empty
      do_recenter();
      chk("R8 underflow cleared", underflow, 0);
      chk("R8 fill recentred", fill, 8);
      for (int i = 0; i < 8; i++) do_read("R8 replay recent bits");
      chk("R3 fill drained", fill, 0);

      // R4 R7: fill from 1 to 16
      for (int k = 1; k <= 16; k++) begin
         do_write(1'((k * 5) % 3 == 1));
         idle();
         chk("R3 fill after write", fill, k);
         probe_stuff(k, "R4 stuff on fill");
         stuff_opp = 1'b0;
      end
      chk("R7 full is not overflow", overflow, 0);
      step(0, 0, 0, 1, 0);
      begin
         bit e;
         e = q.pop_front();
         chk("R5 data at full", rd_bit, e);
      end
      chk("R5 fill after read", fill, 15);

      // R7 overflow
      do_write(1'b1);
      do_write(1'b0);
      idle();
      chk("R7 overflow set", overflow, 1);
      chk("R7 underflow clear", underflow, 0);
      idle();
      chk("R7 overflow sticky", overflow, 1);
      do_recenter();
      chk("R8 overflow cleared", overflow, 0);
      chk("R8 fill after overflow", fill, 8);
      for (int i = 0; i < 3; i++) do_read("R8 recent bits after overflow");

      // R9 bypass
      mode = 2'b10;
      wr_bit = 1'b1; #1;
      chk("R9 bypass passes 1", rd_bit, 1);
      wr_bit = 1'b0; #1;
      chk("R9 bypass passes 0", rd_bit, 0);
      stuff_opp = 1'b1; #1;
      chk("R9 no stuff in bypass", stuff_req, 0);
      stuff_opp = 1'b0;
      for (int i = 0; i < 6; i++) step(1, 1'(i % 2), 1, 1'(i == 3), 0);
      idle();
      chk("R9 fill untouched", fill, 5);
      mode = 2'b00;
      #1;
      for (int i = 0; i < 5; i++) do_read("R9 store preserved");
      idle();
      chk("R3 final fill", fill, 0);
      chk("R6 no spurious underflow", underflow, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule